// File: doc/BRIEF.md
# Per-Bank GPIO Interrupt Detector

This block watches the pins of one GPIO bank and latches interrupt events into status bits. The bank has four ports of eight pins each. Each pin has its own trigger: rising edge, falling edge, either edge, high level or low level. The input is assumed to be synchronized to `clk` already. Edges are found by comparing each pin with the value it had on the previous clock.

Software uses a simple register port. It selects each pin's trigger, sets per-pin enables, and clears status bits by writing ones. A pending status bit whose enable is also set raises the single bank interrupt line. Masked aliases of the status, enable and trigger registers let one write change chosen pins without a read-modify-write. A status bit is recorded whether or not its pin is enabled.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every status, enable and trigger bit reads zero.
- R2: Port p (0..3) has these registers:
  - status at 0x40+4p, 8 bits, read-only at this address;
  - enable at 0x50+4p, 8 bits;
  - trigger at 0x60+4p, 24 bits;
  - clear at 0x70+4p, which reads as zero.
  
  Data bits above a register's width are dropped.
- R3: For pin k, trigger bit k is the polarity, bit 8+k chooses edge over level, and bit 16+k chooses both edges. These settings are edge modes:
  - rising: k and 8+k set;
  - falling: 8+k only;
  - both edges: 8+k and 16+k set.
  
  In an edge mode the status bit is set on the clock at which the pin differs from its previous-clock value in the selected direction.
- R4: Level high is bit k only, and level low is all three bits clear. In a level mode the status bit is set on every clock at which the active level is present. A clear therefore cannot remove the bit while that level remains.
- R5: Writing a one to bit k of the clear register clears status bit k. Zero bits in the write leave status unchanged.
- R6: When a clear and a new event for the same pin take effect on the same clock, the status bit ends set.
- R7: `irq` is high exactly when some port has a status bit set together with its enable bit. Status bits latch even while their enable is zero.
- R8: The masked aliases of status at 0x40+ALIAS+4p and of enable at 0x50+ALIAS+4p (ALIAS defaults to 0x80) take a mask in data bits [15:8] and values in [7:0]. Only bits whose mask bit is one change.
- R9: The masked trigger alias at 0x60+ALIAS+4p takes a mask in data bits [31:24]. Mask bit k loads trigger bits k, 8+k and 16+k from data bits k, 8+k and 16+k. Unmasked pins keep their settings.
- R10: When bit 8+k is clear, bit 16+k is ignored and the pin acts in level mode according to bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 32 | Synchronized pin levels, port p pin k at bit 8p+k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Bank interrupt, any enabled pending status |

## Verification
Two actions can land on the same clock edge: a software clear of a status bit, and a fresh trigger event on that same pin. The bench provokes this by changing the pin and presenting the clear write in the same half-cycle, so both are sampled by one rising edge. A pin held at its active level under a clear is a second version of the same collision. In both cases the status must read set afterwards. The sweeps then compare every trigger mode on every port against pin pattern pairs. Expected bits are worked out arithmetically from the pattern pair.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int N_PORTS   = 4,
  parameter int ADDR_W    = 12,
  parameter int ALIAS_OFS = 'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_PORTS*8-1:0]   pins,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [31:0]            rd_data,
  output logic                   irq
);
  localparam int NPIN = N_PORTS * 8;

  logic [N_PORTS-1:0][7:0]  sta_q, sta_d, enb_q, enb_d, evt;
  logic [N_PORTS-1:0][23:0] cfg_q, cfg_d;
  logic [NPIN-1:0]          prev_q;

  function automatic logic [ADDR_W-1:0] reg_at(input int base, input int p);
    return ADDR_W'(base + 4 * p);
  endfunction

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      for (int k = 0; k < 8; k++) begin
        if (!cfg_q[p][8+k])
          evt[p][k] = (pins[p*8+k] == cfg_q[p][k]);
        else if (cfg_q[p][16+k])
          evt[p][k] = pins[p*8+k] ^ prev_q[p*8+k];
        else if (cfg_q[p][k])
          evt[p][k] = pins[p*8+k] & ~prev_q[p*8+k];
        else
          evt[p][k] = ~pins[p*8+k] & prev_q[p*8+k];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      sta_d[p] = sta_q[p];
      enb_d[p] = enb_q[p];
      cfg_d[p] = cfg_q[p];
      if (wr_en) begin
        if (wr_addr == reg_at('h70, p))
          sta_d[p] = sta_d[p] & ~wr_data[7:0];
        if (wr_addr == reg_at(ALIAS_OFS + 'h40, p))
          sta_d[p] = (sta_d[p] & ~wr_data[15:8]) | (wr_data[7:0] & wr_data[15:8]);
        if (wr_addr == reg_at('h50, p))
          enb_d[p] = wr_data[7:0];
        if (wr_addr == reg_at(ALIAS_OFS + 'h50, p))
          enb_d[p] = (enb_q[p] & ~wr_data[15:8]) | (wr_data[7:0] & wr_data[15:8]);
        if (wr_addr == reg_at('h60, p))
          cfg_d[p] = wr_data[23:0];
        if (wr_addr == reg_at(ALIAS_OFS + 'h60, p))
          cfg_d[p] = (cfg_q[p] & ~{3{wr_data[31:24]}}) | (wr_data[23:0] & {3{wr_data[31:24]}});
      end
      sta_d[p] = sta_d[p] | evt[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q  <= '0;
      enb_q  <= '0;
      cfg_q  <= '0;
      prev_q <= '0;
    end else begin
      sta_q  <= sta_d;
      enb_q  <= enb_d;
      cfg_q  <= cfg_d;
      prev_q <= pins;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (rd_addr == reg_at('h40, p)) rd_data = {24'b0, sta_q[p]};
      if (rd_addr == reg_at('h50, p)) rd_data = {24'b0, enb_q[p]};
      if (rd_addr == reg_at('h60, p)) rd_data = {8'b0, cfg_q[p]};
    end
  end

  assign irq = |(sta_q & enb_q);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int N_PORTS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_PORTS*8-1:0]     pins,
  input logic                     wr_en,
  input logic [N_PORTS-1:0][7:0]  sta_q,
  input logic [N_PORTS-1:0][7:0]  enb_q,
  input logic [N_PORTS-1:0][23:0] cfg_q,
  input logic                     irq
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (sta_q == '0 && enb_q == '0 && cfg_q == '0));

  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(enb_q) && $stable(cfg_q)));

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0][0] && cfg_q[0][8] && !cfg_q[0][16] && $rose(pins[0])) |=> sta_q[0][0]);

  p_level_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0][0] && !cfg_q[0][8] && pins[0]) |=> sta_q[0][0]);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sta_q) & ~sta_q)) |-> $past(wr_en));

  p_no_enable_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enb_q) == '0 && !$past(wr_en)) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en),
  .sta_q(sta_q), .enb_q(enb_q), .cfg_q(cfg_q), .irq(irq)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] pins = 0, wr_data = 0, rd_data;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic        irq;
  int n_run = 0, n_fail = 0;

  gpio_irq_bank u_dut (.clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  function automatic logic [23:0] mode_cfg(input int m);
    case (m)
      0: return 24'h00FFFF;
      1: return 24'h00FF00;
      2: return 24'hFFFF00;
      3: return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  task automatic sweep(input int m, input int p, input logic [7:0] a, input logic [7:0] b);
    logic [31:0] v;
    logic [7:0] e1, e2;
    case (m)
      0: begin e1 = b & ~a; e2 = 8'h00; end
      1: begin e1 = a & ~b; e2 = 8'h00; end
      2: begin e1 = a ^ b;  e2 = 8'h00; end
      3: begin e1 = a | b;  e2 = b;     end
      default: begin e1 = ~a | ~b; e2 = ~b; end
    endcase
    @(negedge clk); pins[p*8 +: 8] = a;
    wr(12'(32'h60 + 4*p), {8'h0, mode_cfg(m)});
    wr(12'(32'h70 + 4*p), 32'hFF);
    pins[p*8 +: 8] = b;
    @(negedge clk);
    rd(12'(32'h40 + 4*p), v);
    chk(m < 3 ? "R3 edge sweep" : "R4 level sweep", v, {24'h0, e1});
    wr(12'(32'h70 + 4*p), 32'hFF);
    rd(12'(32'h40 + 4*p), v);
    chk(m < 3 ? "R5 edge clear" : "R4 level reassert", v, {24'h0, e2});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] pa[4], pb[4];
    pa = '{8'h00, 8'hFF, 8'hA5, 8'h0F};
    pb = '{8'hFF, 8'h00, 8'h5A, 8'h3C};
    #1;
    rd(12'h40, v); chk("R1 status in reset", v, 0);
    rd(12'h54, v); chk("R1 enable in reset", v, 0);
    rd(12'h6C, v); chk("R1 trigger in reset", v, 0);
    @(negedge clk); rst_n = 1;
    rd(12'h5C, v); chk("R1 enable after reset", v, 0);
    @(negedge clk);
    rd(12'h40, v); chk("R7 status latches while disabled", v, 32'hFF);
    chk("R7 irq low with no enable", {31'b0, irq}, 0);

    wr(12'h54, 32'h000000A5); rd(12'h54, v); chk("R2 enable readback", v, 32'hA5);
    wr(12'h6C, 32'hFF123456); rd(12'h6C, v); chk("R2 trigger 24 bit", v, 32'h123456);
    rd(12'h70, v); chk("R2 clear reads zero", v, 0);
    wr(12'h58, 32'hFFFFFF3C); rd(12'h58, v); chk("R2 enable width", v, 32'h3C);
    wr(12'h40, 32'h00000000); rd(12'h40, v); chk("R2 status read-only", v, 32'hFF);

    wr(12'hD4, 32'h00000F0A); rd(12'h54, v); chk("R8 masked enable", v, 32'hAA);
    wr(12'hEC, 32'h81FFFFFF); rd(12'h6C, v); chk("R9 masked trigger", v, 32'h93B5D7);

    wr(12'h68, 32'h0000FFFF);
    wr(12'h78, 32'hFF); rd(12'h48, v); chk("R5 clear all", v, 0);
    wr(12'hC8, 32'h0000F030); rd(12'h48, v); chk("R8 masked status", v, 32'h30);
    wr(12'h78, 32'h10); rd(12'h48, v); chk("R5 clear one bit", v, 32'h20);
    wr(12'h78, 32'h00); rd(12'h48, v); chk("R5 zero write no effect", v, 32'h20);

    wr(12'h54, 0); wr(12'h58, 0);
    wr(12'h58, 32'h01); chk("R7 irq off, no overlap", {31'b0, irq}, 0);
    wr(12'h58, 32'h20); chk("R7 irq on overlap", {31'b0, irq}, 1);
    wr(12'h78, 32'hFF); chk("R7 irq drops after clear", {31'b0, irq}, 0);

    @(negedge clk); pins[16] = 1; wr_en = 1; wr_addr = 12'h78; wr_data = 32'h01;
    @(negedge clk); wr_en = 0;
    rd(12'h48, v); chk("R6 event beats clear", v, 32'h01);
    wr(12'h78, 32'h01); rd(12'h48, v); chk("R6 clear after event", v, 0);

    rd(12'h40, v); chk("R4 level low pending", v, 32'hFF);
    wr(12'h70, 32'hFF); rd(12'h40, v); chk("R4 clear under level", v, 32'hFF);
    @(negedge clk); pins[7:0] = 8'hFF; @(negedge clk);
    wr(12'h70, 32'hFF); rd(12'h40, v); chk("R4 clear after level gone", v, 0);

    wr(12'h64, 32'h00FF00FF); @(negedge clk); pins[15:8] = 8'h0F; @(negedge clk);
    wr(12'h74, 32'hFF); rd(12'h44, v); chk("R10 both bit ignored as level", v, 32'h0F);

    for (int m = 0; m < 5; m++)
      for (int p = 0; p < 4; p++)
        for (int i = 0; i < 4; i++)
          sweep(m, p, pa[i], pb[i]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule